// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register side of a simple byte-wide serial port. A host reaches it over a 32-bit register bus that carries a word address, a write strobe and a read strobe. Read data comes back combinationally in the same cycle as the read strobe. Writes and read side effects take effect at the next rising clock edge.

Transmit bytes leave on a valid/ready byte stream, and the block holds at most one of them. Received bytes arrive on a second byte stream. The block answers that stream with an accept signal and keeps the last accepted byte together with a data-available flag. Two events set sticky raw interrupt bits: a byte being queued for transmit and a byte being received. Software clears these bits by writing ones to an acknowledge address. A mask register selects which raw bits drive the single level interrupt output.

The word index on the bus is the byte offset divided by four. The decoded window holds word indices 0 to 14, which are byte offsets 0x00 to 0x38.

Top module: `sport_regfront`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x01400000: bit 24 (tx ready) and bit 22 (tx idle) are set and everything else is clear. After the same reset, the raw interrupt reads 0, `irq` is low and `tx_valid` is low.
- R2: Offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x28 and 0x2C are plain 32-bit storage. Each reads back the last value written to it. Offset 0x08 is receive control, and its bit 0 is the receive override. Offset 0x2C is the interrupt mask.
- R3: A read at byte offset 0x3C or above returns 0. A write at byte offset 0x3C or above changes no register.
- R4: A write to offset 0x1C while no transmit byte is pending does three things from the next cycle on. It raises `tx_valid` with `tx_data` equal to bits 7:0 of the written value. It sets raw interrupt bit 0. It makes offset 0x1C read back the full written value. `tx_valid` drops in the cycle after a cycle in which `tx_valid` and `tx_ready` are both high.
- R5: While a transmit byte is pending, status bits 24 and 22 read 0. While a byte is pending, a write to 0x1C is dropped: `tx_data`, the 0x1C readback and the raw interrupt all stay unchanged.
- R6: When `rx_valid` and `rx_accept` are both high, from the next cycle on the status word bits 7:0 hold the byte, bit 16 (data available) is set, and raw interrupt bit 3 is set.
- R7: `rx_accept` is high exactly when bit 0 of receive control is set or raw interrupt bit 3 is clear. A byte offered while `rx_accept` is low changes nothing.
- R8: The status word reads at both 0x20 and 0x24. A read at 0x20 clears bit 16 from the next cycle on. A read at 0x24 has no side effect. A byte received in the same cycle as a read at 0x20 leaves bit 16 set.
- R9: A write to 0x30 clears every raw interrupt bit that is set in the written value. Offset 0x30 always reads 0. A raw bit set by an event in the same cycle as the write stays set.
- R10: Offset 0x38 reads raw AND mask. Offset 0x34 reads the raw interrupt. `irq` is high exactly when raw AND mask is nonzero.
- R11: Writes to 0x20, 0x24, 0x34 and 0x38 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_word | input | ADDR_W (6) | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_ready | input | 1 | The downstream side takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | A received byte is offered |
| rx_data | input | 8 | Received byte |
| rx_accept | output | 1 | The block takes the offered byte |
| irq | output | 1 | Level interrupt |

## Verification
`bus_rdata` and `rx_accept` are combinational, so they are due in the same cycle as their inputs. Register state, `tx_valid`, `tx_data` and `irq` change one edge after a write, a read side effect, a handshake or a receive. The bench drives every input at the falling edge and compares outputs 2 ns later against a behavioural model. It advances that model one step just after each rising edge. Same-cycle collisions (a read at 0x20 against a receive, an acknowledge against a receive, a repeated data-out write against a pending byte) are driven on purpose, so the order of the updates is checked.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int REG_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int WIN_WORDS = 15;
  // word indices (byte offset / 4)
  localparam int W_TXCTL  = 0;
  localparam int W_RXCTL  = 2;
  localparam int W_DOUT   = 7;
  localparam int W_STAT_C = 8;   // read clears data-available
  localparam int W_STAT_P = 9;   // read has no side effect
  localparam int W_MASK   = 11;
  localparam int W_ACK    = 12;
  localparam int W_RAW    = 13;
  localparam int W_MASKED = 14;
  // status word bit positions
  localparam int B_DAV  = 16;
  localparam int B_IDLE = 22;
  localparam int B_RDY  = 24;
  // raw interrupt bit positions
  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 3;

  function automatic logic is_plain(input int idx);
    return (idx >= W_TXCTL && idx < W_DOUT) || idx == 10 || idx == W_MASK;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic [BYTE_W-1:0] rxb,
                                                   input logic dav,
                                                   input logic tx_busy);
    logic [REG_W-1:0] w;
    w = '0;
    w[BYTE_W-1:0] = rxb;
    w[B_DAV]  = dav;
    w[B_IDLE] = ~tx_busy;
    w[B_RDY]  = ~tx_busy;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] ack_apply(input logic [REG_W-1:0] raw,
                                                 input logic [REG_W-1:0] ack,
                                                 input logic [REG_W-1:0] set_vec);
    return (raw & ~ack) | set_vec;
  endfunction
endpackage

// File: rtl/sport_tx_slot.sv
module sport_tx_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_rx_hold.sv
module sport_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_fire,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_clr,
  output logic [BYTE_W-1:0] held_byte,
  output logic              dav
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_byte <= '0;
      dav       <= 1'b0;
    end else if (rx_fire) begin
      held_byte <= rx_byte;
      dav       <= 1'b1;   // a new byte wins over a clearing read
    end else if (rd_clr) begin
      dav       <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_irq_unit.sv
module sport_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         ack_en,
  input  logic [W-1:0] ack_val,
  input  logic [W-1:0] mask,
  output logic [W-1:0] raw,
  output logic [W-1:0] masked,
  output logic         irq
);
  logic [W-1:0] ack_eff;
  assign ack_eff = ack_en ? ack_val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= sport_pkg::ack_apply(raw, ack_eff, set_vec);
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/sport_regfront.sv
module sport_regfront #(
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_word,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [sport_pkg::REG_W-1:0]   bus_wdata,
  output logic [sport_pkg::REG_W-1:0]   bus_rdata,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [sport_pkg::BYTE_W-1:0]  tx_data,
  input  logic                          rx_valid,
  input  logic [sport_pkg::BYTE_W-1:0]  rx_data,
  output logic                          rx_accept,
  output logic                          irq
);
  import sport_pkg::*;
  localparam int NW = WIN_WORDS;

  logic in_win;
  logic [REG_W-1:0] store [NW];
  logic [NW-1:0] we_vec;
  logic dout_take, rx_fire, rd_clr, ack_wr, dav;
  logic [BYTE_W-1:0] held_byte;
  logic [REG_W-1:0] raw, masked, set_vec, stat;

  assign in_win    = int'(bus_word) < NW;
  assign dout_take = bus_wr && int'(bus_word) == W_DOUT && !tx_valid;
  assign ack_wr    = bus_wr && int'(bus_word) == W_ACK;
  assign rd_clr    = bus_rd && int'(bus_word) == W_STAT_C;
  assign rx_accept = store[W_RXCTL][0] | ~raw[IRQ_RX];
  assign rx_fire   = rx_valid && rx_accept;

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_TX] = dout_take;
    set_vec[IRQ_RX] = rx_fire;
  end

  // per-word write enables; the data-out word stores only accepted writes
  for (genvar i = 0; i < NW; i++) begin : g_we
    if (is_plain(i)) begin : g_plain
      assign we_vec[i] = bus_wr && in_win && int'(bus_word) == i;
    end else if (i == W_DOUT) begin : g_dout
      assign we_vec[i] = dout_take;
    end else begin : g_ro
      assign we_vec[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (!rst_n)         store[i] <= '0;
      else if (we_vec[i]) store[i] <= bus_wdata;
    end
  end

  sport_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(dout_take), .load_byte(bus_wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  sport_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_fire(rx_fire), .rx_byte(rx_data),
    .rd_clr(rd_clr), .held_byte(held_byte), .dav(dav)
  );

  sport_irq_unit #(.W(REG_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .ack_en(ack_wr), .ack_val(bus_wdata),
    .mask(store[W_MASK]), .raw(raw), .masked(masked), .irq(irq)
  );

  assign stat = status_word(held_byte, dav, tx_valid);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && in_win) begin
      case (int'(bus_word))
        W_STAT_C, W_STAT_P: bus_rdata = stat;
        W_ACK:              bus_rdata = '0;
        W_RAW:              bus_rdata = raw;
        W_MASKED:           bus_rdata = masked;
        default:            bus_rdata = store[int'(bus_word)];
      endcase
    end
  end
endmodule

// File: rtl/sport_regfront_chk.sv
module sport_regfront_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_word,
  input logic [31:0]       bus_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              rx_accept,
  input logic              rx_fire,
  input logic              rd_clr,
  input logic              dav,
  input logic [31:0]       raw,
  input logic [31:0]       mask_reg,
  input logic              rx_ovr,
  input logic              irq
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!tx_valid && raw == 32'd0));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_rx_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> (dav && raw[3]));

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_accept |-> (!rx_ovr && raw[3]));

  assert_dav_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !rx_fire) |=> !dav);

  assert_ack_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_word == ADDR_W'(12)) |-> bus_rdata == 32'd0);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw & mask_reg) != 32'd0));
endmodule

bind sport_regfront sport_regfront_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_word(bus_word), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_accept(rx_accept),
  .rx_fire(rx_fire), .rd_clr(rd_clr), .dav(dav), .raw(raw), .mask_reg(store[11]),
  .rx_ovr(store[2][0]), .irq(irq)
);

// File: tb/sport_regfront_tb_top.sv
module sport_regfront_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_word = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_accept, irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int unsigned m_store [15];
  bit m_txv;
  int unsigned m_txd, m_rxb, m_raw;
  bit m_dav;

  always #4 clk = ~clk;

  sport_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .rx_accept(rx_accept), .irq(irq)
  );

  function automatic int unsigned m_status();
    return (m_txv ? 0 : 32'h0140_0000) | (m_dav ? 32'h1_0000 : 0) | m_rxb;
  endfunction

  function automatic int unsigned m_read(int w);
    if (w >= 15) return 0;
    if (w == 8 || w == 9) return m_status();
    if (w == 12) return 0;
    if (w == 13) return m_raw;
    if (w == 14) return m_raw & m_store[11];
    return m_store[w];
  endfunction

  function automatic bit m_accept();
    return m_store[2][0] || !m_raw[3];
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_store[i]) m_store[i] = 0;
    m_txv = 0; m_txd = 0; m_rxb = 0; m_raw = 0; m_dav = 0;
  endtask

  // one bus cycle: drive at the falling edge, compare, then advance the model
  task automatic step(bit wr, bit rd, int off, int unsigned wd, bit rxv, int unsigned rxd,
                      bit trdy, string tag);
    int w;
    bit fire, old_txv;
    w = off / 4;
    bus_wr = wr; bus_rd = rd; bus_word = 6'(w); bus_wdata = wd;
    rx_valid = rxv; rx_data = 8'(rxd); tx_ready = trdy;
    #2;
    if (rd) check(tag, bus_rdata, m_read(w));
    check("R10 irq", 32'(irq), ((m_raw & m_store[11]) != 0) ? 1 : 0);
    check("R4 tx_valid", 32'(tx_valid), 32'(m_txv));
    if (m_txv) check("R4 tx_data", 32'(tx_data), m_txd);
    check("R7 rx_accept", 32'(rx_accept), 32'(m_accept()));
    @(posedge clk); #1;
    fire = rxv && m_accept();
    old_txv = m_txv;
    if (m_txv && trdy) m_txv = 0;
    if (wr && w < 15) begin
      if (w < 7 || w == 10 || w == 11) m_store[w] = wd;
      if (w == 12) m_raw = m_raw & ~wd;
      if (w == 7 && !old_txv) begin
        m_store[7] = wd; m_txv = 1; m_txd = wd & 8'hFF; m_raw = m_raw | 1;
      end
    end
    if (rd && w == 8) m_dav = 0;
    if (fire) begin m_dav = 1; m_rxb = rxd & 8'hFF; m_raw = m_raw | 8; end
    @(negedge clk);
  endtask

  task automatic wr_reg(int off, int unsigned v);
    step(1, 0, off, v, 0, 0, 0, "wr");
  endtask
  task automatic rd_reg(int off, string tag);
    step(0, 1, off, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd_reg('h24, "R1 status");
    rd_reg('h34, "R1 raw");
    // R2 plain storage
    wr_reg('h00, 32'hDEAD_BEEF); wr_reg('h04, 32'h1234_5678); wr_reg('h0C, 32'hA5A5_0F0F);
    wr_reg('h18, 32'h0000_0042); wr_reg('h28, 32'hFFFF_0001); wr_reg('h08, 32'h0000_0002);
    rd_reg('h00, "R2 txctl"); rd_reg('h04, "R2 dma"); rd_reg('h0C, "R2 spare");
    rd_reg('h18, "R2 spare2"); rd_reg('h28, "R2 spare3"); rd_reg('h08, "R2 rxctl");
    // R3 outside the window
    wr_reg('h3C, 32'hFFFF_FFFF); wr_reg('h80, 32'h0000_00FF);
    rd_reg('h3C, "R3 0x3C"); rd_reg('hFC, "R3 0xFC"); rd_reg('h00, "R3 txctl intact");
    // R11 writes to read-only words
    wr_reg('h20, 32'hFFFF_FFFF); wr_reg('h24, 32'hFFFF_FFFF);
    wr_reg('h34, 32'hFFFF_FFFF); wr_reg('h38, 32'hFFFF_FFFF);
    rd_reg('h24, "R11 status"); rd_reg('h34, "R11 raw");
    // R4 transmit, R5 pending behaviour
    wr_reg('h1C, 32'h0000_01A5);
    rd_reg('h1C, "R4 dout readback"); rd_reg('h34, "R4 raw tx bit");
    rd_reg('h24, "R5 status busy");
    wr_reg('h1C, 32'h0000_0077);
    rd_reg('h1C, "R5 dropped write");
    step(0, 0, 0, 0, 0, 0, 1, "R4 handshake");
    rd_reg('h24, "R5 status idle again");
    // R10 mask and irq
    wr_reg('h2C, 32'h0000_0009);
    rd_reg('h38, "R10 masked");
    // R9 acknowledge
    wr_reg('h30, 32'h0000_0001);
    rd_reg('h34, "R9 raw after ack"); rd_reg('h30, "R9 ack reads zero");
    // R6 receive
    step(0, 0, 0, 0, 1, 'h3C, 0, "R6 rx");
    rd_reg('h24, "R6 status byte"); rd_reg('h38, "R10 masked rx");
    // R7 refused byte
    step(0, 0, 0, 0, 1, 'h55, 0, "R7 refused");
    rd_reg('h24, "R7 byte unchanged");
    // override enable, then R8 reads
    wr_reg('h08, 32'h0000_0001);
    step(0, 0, 0, 0, 1, 'h66, 0, "R7 override");
    rd_reg('h24, "R8 peek"); rd_reg('h24, "R8 peek no clear");
    rd_reg('h20, "R8 clearing read"); rd_reg('h24, "R8 dav cleared");
    // R8 same-cycle receive wins over clearing read
    step(0, 1, 'h20, 0, 1, 'h81, 0, "R8 collide read");
    rd_reg('h24, "R8 dav kept");
    // R9 same-cycle receive wins over acknowledge
    step(1, 0, 'h30, 32'h0000_0008, 1, 'h92, 0, "R9 collide ack");
    rd_reg('h34, "R9 raw kept");
    wr_reg('h30, 32'hFFFF_FFFF);
    rd_reg('h34, "R9 raw cleared"); rd_reg('h38, "R10 masked clear");
    // transmit again with pending write plus ack collision
    step(1, 0, 'h1C, 32'h0000_00C3, 0, 0, 1, "R4 second tx");
    step(1, 0, 'h30, 32'h0000_0001, 0, 0, 0, "R9 ack tx");
    rd_reg('h34, "R9 raw after tx ack");
    step(0, 0, 0, 0, 0, 0, 1, "R4 drain");
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    // reset again: R1
    rst_n = 1'b0; model_reset();
    @(posedge clk); @(negedge clk); rst_n = 1'b1;
    rd_reg('h24, "R1 status after reset"); rd_reg('h2C, "R1 mask after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule